// File: doc/BRIEF.md
# CPU-Cycle Interval Interrupt Counter

This block is a free-running interval counter for a cartridge-style bank controller. A 15-bit up-counter advances by one on every CPU-cycle strobe while it is armed. The interrupt request it drives is a level, not a pulse. It stays high for as long as the armed count is at or above a threshold (default `0x6000`). It falls by itself when the counter rolls over from `0x7FFF` to zero. There is no reload value and no terminal-count event.

Software controls the block through a single write-only register. Setting data bit 1 arms the counter. Clearing data bit 1 disarms it, zeroes the count and withdraws the interrupt in one step. The block runs on a system clock that may be faster than the CPU. The one-cycle `cyc_tick` strobe marks each CPU cycle. The count is brought out on `cnt_o` for observation.

Internally a three-state controller sequences the block:
- **IDLE**: disarmed, count held at zero.
- **BELOW**: armed, count under the threshold.
- **ABOVE**: armed, count at or over the threshold; `irq_o` is high.

The transitions are:
- **arm**: IDLE to BELOW, on a control write with bit 1 set.
- **cross**: BELOW to ABOVE, on a tick that brings the count to the threshold.
- **wrap**: ABOVE to BELOW, on the tick that rolls `0x7FFF` to zero.
- **disarm**: any state to IDLE, on a control write with bit 1 clear.

Top module: `cyc_irq_timer`

## Requirements
- R1: After reset `irq_o` is 0, `cnt_o` is 0 and the block is disarmed, so later ticks do not advance the count until it is armed.
- R2: While armed, each cycle with `cyc_tick` high raises `cnt_o` by exactly one, modulo 2^15.
- R3: A cycle with `cyc_tick` low leaves `cnt_o` unchanged, so ticks spaced by idle cycles are counted one each.
- R4: While armed, `irq_o` is 1 exactly when `cnt_o` >= `0x6000`. Starting from zero, it is 0 after `0x5FFF` ticks and 1 after `0x6000` ticks.
- R5: The tick taken at `cnt_o` = `0x7FFF` wraps the count to 0, and `irq_o` drops with no write.
- R6: A control write with data bit 1 = 0 clears `cnt_o` and `irq_o` on the next cycle and disarms the block.
- R7: While disarmed, `cnt_o` stays 0 and `irq_o` stays 0 for any number of ticks.
- R8: A control write with data bit 1 = 1 while already armed leaves the count value unchanged.
- R9: A write reaches the control register only when (`wr_addr` & `0xE003`) == `0xE002`, so mirrors such as `0xFFFE` and `0xF00A` also hit it. Writes to other addresses are ignored, and only data bit 1 is used.
- R10: When a write and a tick fall in the same cycle: a disarm wins, so the count becomes 0; an arm from the disarmed state does not count that tick; a re-arm while armed does count it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_tick | input | 1 | One-cycle strobe, one per CPU cycle |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| irq_o | output | 1 | Level interrupt request |
| cnt_o | output | 15 | Current counter value |

## Verification
A control write and a CPU-cycle tick can arrive in the same system clock cycle. The bench drives both strobes together in three states: disarm during ABOVE, arm from IDLE, and re-arm during BELOW. Each outcome is judged from `cnt_o` and `irq_o` one cycle later against the precedence in R10. The threshold crossing and the wrap are judged at the exact tick counts `0x5FFF`, `0x6000`, `0x7FFF` and `0x8000`.

// File: rtl/cyc_irq_pkg.sv
package cyc_irq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BELOW = 2'd1,
        ST_ABOVE = 2'd2
    } tmr_state_e;

endpackage

// File: rtl/cyc_irq_decode.sv
module cyc_irq_decode #(
    parameter int          AW         = 16,
    parameter int          DW         = 8,
    parameter logic [15:0] ADDR_MASK  = 16'hE003,
    parameter logic [15:0] ADDR_MATCH = 16'hE002,
    parameter int          ARM_BIT    = 1
) (
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          arm_req,
    output logic          disarm_req
);
    localparam logic [AW-1:0] MASK  = AW'(ADDR_MASK);
    localparam logic [AW-1:0] MATCH = AW'(ADDR_MATCH);

    logic hit;

    always_comb begin
        hit        = wr_en && ((wr_addr & MASK) == MATCH);
        arm_req    = hit &&  wr_data[ARM_BIT];
        disarm_req = hit && !wr_data[ARM_BIT];
    end

    always_comb begin
        assert (!(arm_req && disarm_req)) else $error("p_req_excl_r9");
    end
endmodule

// File: rtl/cyc_irq_count.sv
module cyc_irq_count #(
    parameter int CW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          clr,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_nxt
);
    localparam logic [CW-1:0] ONE = CW'(1);

    always_comb begin
        cnt_nxt = cnt_q + ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (clr)  cnt_q <= '0;
        else if (inc)  cnt_q <= cnt_nxt;
    end

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> (cnt_q == CW'($past(cnt_q) + 1)));
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(cnt_q));
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && (&cnt_q)) |=> (cnt_q == '0));
endmodule

// File: rtl/cyc_irq_cmp.sv
module cyc_irq_cmp #(
    parameter int          CW     = 15,
    parameter logic [14:0] THRESH = 15'h6000
) (
    input  logic [CW-1:0] val,
    output logic          at_or_above
);
    localparam logic [CW-1:0] TH = CW'(THRESH);

    generate
        if (TH == '0) begin : g_always
            assign at_or_above = 1'b1;
        end else begin : g_compare
            assign at_or_above = (val >= TH);
        end
    endgenerate
endmodule

// File: rtl/cyc_irq_ctrl.sv
module cyc_irq_ctrl
    import cyc_irq_pkg::*;
#(
    parameter int          CW     = 15,
    parameter logic [14:0] THRESH = 15'h6000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          arm_req,
    input  logic          disarm_req,
    input  logic          nxt_above,
    input  logic [CW-1:0] cnt_i,
    output logic          inc,
    output logic          clr,
    output logic          irq_o
);
    localparam logic [CW-1:0] TH = CW'(THRESH);

    tmr_state_e st_q, st_d;

    always_comb begin
        clr  = disarm_req;
        inc  = tick && (st_q != ST_IDLE) && !disarm_req;
        st_d = st_q;
        if (disarm_req) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:  if (arm_req) st_d = (TH == '0) ? ST_ABOVE : ST_BELOW;
                ST_BELOW: if (inc && nxt_above)  st_d = ST_ABOVE;
                ST_ABOVE: if (inc && !nxt_above) st_d = ST_BELOW;
                default:  st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= (st_d == ST_ABOVE);
    end

    p_irq_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |-> (irq_o == (cnt_i >= TH)));
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> (!irq_o && cnt_i == '0));
    p_disarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        disarm_req |=> (!irq_o && st_q == ST_IDLE));
    p_arm_notick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && arm_req && !disarm_req) |-> !inc);
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer #(
    parameter int          CW         = 15,
    parameter logic [14:0] THRESH     = 15'h6000,
    parameter logic [15:0] ADDR_MASK  = 16'hE003,
    parameter logic [15:0] ADDR_MATCH = 16'hE002,
    parameter int          ARM_BIT    = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_tick,
    input  logic          wr_en,
    input  logic [15:0]   wr_addr,
    input  logic [7:0]    wr_data,
    output logic          irq_o,
    output logic [CW-1:0] cnt_o
);
    logic          arm_req, disarm_req;
    logic          inc, clr, nxt_above;
    logic [CW-1:0] cnt_q, cnt_nxt;

    cyc_irq_decode #(
        .AW(16), .DW(8), .ADDR_MASK(ADDR_MASK),
        .ADDR_MATCH(ADDR_MATCH), .ARM_BIT(ARM_BIT)
    ) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .arm_req(arm_req), .disarm_req(disarm_req)
    );

    cyc_irq_count #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(inc), .clr(clr),
        .cnt_q(cnt_q), .cnt_nxt(cnt_nxt)
    );

    cyc_irq_cmp #(.CW(CW), .THRESH(THRESH)) u_cmp (
        .val(cnt_nxt), .at_or_above(nxt_above)
    );

    cyc_irq_ctrl #(.CW(CW), .THRESH(THRESH)) u_ctl (
        .clk(clk), .rst_n(rst_n), .tick(cyc_tick),
        .arm_req(arm_req), .disarm_req(disarm_req),
        .nxt_above(nxt_above), .cnt_i(cnt_q),
        .inc(inc), .clr(clr), .irq_o(irq_o)
    );

    assign cnt_o = cnt_q;

    p_ignore_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_tick && (!wr_en || ((wr_addr & ADDR_MASK) != ADDR_MATCH)))
        |=> ($stable(cnt_o) && $stable(irq_o)));
endmodule

// File: tb/tb_cyc_irq_timer.sv
module tb_cyc_irq_timer;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 190000;
    localparam int NV = 17;

    // {kind[1:0], addr[15:0], data[7:0], n[15:0], irq, cnt[14:0]}
    // kind 0 = control write, 1 = back-to-back ticks, 2 = ticks with idle gaps
    localparam logic [57:0] VEC [NV] = '{
        {2'd1, 16'h0000, 8'h00, 16'h7FFF, 1'b0, 15'h0000}, // R7 disarmed after reset
        {2'd0, 16'hE002, 8'h02, 16'h0000, 1'b0, 15'h0000}, // arm
        {2'd1, 16'h0000, 8'h00, 16'h5FFF, 1'b0, 15'h5FFF}, // R4 below threshold, R2
        {2'd1, 16'h0000, 8'h00, 16'h0001, 1'b1, 15'h6000}, // R4 crossing
        {2'd1, 16'h0000, 8'h00, 16'h1FFF, 1'b1, 15'h7FFF}, // R4 held
        {2'd1, 16'h0000, 8'h00, 16'h0001, 1'b0, 15'h0000}, // R5 wrap
        {2'd2, 16'h0000, 8'h00, 16'h0200, 1'b0, 15'h0200}, // R3 gapped ticks
        {2'd0, 16'hE002, 8'hFE, 16'h0000, 1'b0, 15'h0200}, // R8 re-arm keeps count
        {2'd0, 16'hE002, 8'h00, 16'h0000, 1'b0, 15'h0000}, // R6 disarm
        {2'd1, 16'h0000, 8'h00, 16'h0064, 1'b0, 15'h0000}, // R7
        {2'd0, 16'hE002, 8'h02, 16'h0000, 1'b0, 15'h0000}, // arm
        {2'd1, 16'h0000, 8'h00, 16'h0010, 1'b0, 15'h0010}, // R2
        {2'd0, 16'hE003, 8'h00, 16'h0000, 1'b0, 15'h0010}, // R9 miss
        {2'd0, 16'h8002, 8'h00, 16'h0000, 1'b0, 15'h0010}, // R9 miss
        {2'd0, 16'hF00A, 8'hFD, 16'h0000, 1'b0, 15'h0000}, // R9 mirror, bit1 only
        {2'd0, 16'hFFFE, 8'h02, 16'h0000, 1'b0, 15'h0000}, // R9 mirror arm
        {2'd1, 16'h0000, 8'h00, 16'h0005, 1'b0, 15'h0005}  // R2
    };
    localparam int REQ [NV] = '{7, 8, 4, 4, 4, 5, 3, 8, 6, 7, 8, 2, 9, 9, 9, 9, 2};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        irq_o;
    logic [14:0] cnt_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    cyc_irq_timer dut (
        .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .irq_o(irq_o), .cnt_o(cnt_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= WDOG_LIMIT && !done) begin
            done = 1'b1;
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WDOG_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input logic ei, input logic [14:0] ec);
        checks++;
        if (irq_o !== ei || cnt_o !== ec) begin
            errors++;
            $display("FAIL %s: actual irq=%0b cnt=%h expected irq=%0b cnt=%h",
                     tag, irq_o, cnt_o, ei, ec);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d, input logic tk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; cyc_tick = tk;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; cyc_tick = 1'b0;
    endtask

    task automatic do_ticks(input int n, input bit gapped);
        if (n == 0) return;
        @(negedge clk);
        if (gapped) begin
            for (int i = 0; i < n; i++) begin
                cyc_tick = 1'b1;
                @(negedge clk);
                cyc_tick = 1'b0;
                @(negedge clk);
            end
        end else begin
            cyc_tick = 1'b1;
            repeat (n) @(negedge clk);
            cyc_tick = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state", 1'b0, 15'h0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            logic [1:0]  kind;
            logic [15:0] a, n;
            logic [7:0]  d;
            logic        ei;
            logic [14:0] ec;
            {kind, a, d, n, ei, ec} = VEC[v];
            if (kind == 2'd0) do_write(a, d, 1'b0);
            else              do_ticks(int'(n), kind == 2'd2);
            check($sformatf("R%0d table row %0d", REQ[v], v), ei, ec);
        end

        // count is 5, armed
        do_write(16'hE002, 8'h02, 1'b1);
        check("R10 re-arm with tick counts it (R8)", 1'b0, 15'h0006);
        do_ticks(16'h5FFA, 1'b0);
        check("R4 crossing again", 1'b1, 15'h6000);
        do_write(16'hE002, 8'h00, 1'b1);
        check("R10 disarm beats tick", 1'b0, 15'h0000);
        do_write(16'hE002, 8'h02, 1'b1);
        check("R10 arm from idle ignores tick", 1'b0, 15'h0000);
        do_ticks(3, 1'b0);
        check("R2 after arm", 1'b0, 15'h0003);

        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 reset mid-count", 1'b0, 15'h0000);
        do_ticks(5, 1'b0);
        check("R1 disarmed after reset", 1'b0, 15'h0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule